// File: doc/BRIEF.md
# CSR Access Check and Update Sequencer

This block sits between a processor's instruction decode and its bank of control and status registers. Each request carries a 12-bit register address, the hart's current privilege level, an operation code, a data word and a write mask. The block decides whether the access is allowed. It drives the address onto the bank's read port and forms the merged write value from the old contents. It then raises a write strobe only for a legal access that actually changes bits. The old value goes back to the destination register, or the illegal flag is raised for the trap logic.

The permission rules come from the address itself. Two address bits give the lowest privilege that may touch the register. Two other bits mark it read-only. The user-level counter window is also gated per counter index by the machine and supervisor counter-enable words, which the bank supplies. Addresses outside the implemented map are refused. All results are combinational, so they appear in the same cycle as the request.

Top module: `csr_access_gate`

## Requirements
- R1: Privilege is encoded user=0, supervisor=1, machine=3. A request is illegal when `priv` is numerically lower than address bits [9:8].
- R2: An address whose bits [11:10] are 3 is read-only. A request to it with a nonzero effective mask is illegal. With a zero effective mask it is a legal read.
- R3: The write data is (old AND NOT mask) OR (new AND mask), where old is `bank_rdata`. The write address equals the request address.
- R4: `bank_we` is high only for a valid, legal request whose effective mask is nonzero. A zero mask gives a pure read with no strobe.
- R5: `op` selects the effective new/mask pair. 0 takes `new_val` and `wr_mask` as given. 1 (swap) takes `new_val` under an all-ones mask. 2 (set) takes all-ones under mask `new_val`. 3 (clear) takes zero under mask `new_val`. For op 1 to 3, `wr_mask` has no effect.
- R6: `rdata` returns the old value (`bank_rdata`) for a legal valid request. It is zero when the request is illegal or `req_valid` is low, and `illegal` is low without a request.
- R7: For user counters at 0xC00..0xC1F and, when XLEN is 32, their upper halves at 0xC80..0xC9F, an enable word starts as all ones. Below machine mode it is ANDed with `m_ctr_en`. In user mode it is also ANDed with `s_ctr_en`. The access is illegal when bit (address mod 32) of that word is clear. Machine counters at 0xB00..0xB1F are not gated.
- R8: Implemented addresses are 0x001..0x003, 0x300..0x306, 0x323..0x33F, 0x340..0x344 and 0xF11..0xF14. The counter windows 0xC00/0xB00 (and 0xC80/0xB80 for XLEN 32) are implemented for indices below NUM_CTR. With supervisor support, 0x100..0x106, 0x140..0x144 and 0x180 are implemented too. Any other address is illegal.
- R9: With parameter HAS_SMODE = 0, the supervisor addresses of R8 report illegal even from machine mode.
- R10: All outputs follow the inputs combinationally. `bank_raddr` always equals `csr_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | 1 | Access request present |
| csr_addr | input | 12 | Register address |
| priv | input | 2 | Current privilege level |
| op | input | 2 | Operation: 0 raw, 1 swap, 2 set, 3 clear |
| new_val | input | XLEN | New value (raw) or operand (ops 1..3) |
| wr_mask | input | XLEN | Write mask for op 0 |
| m_ctr_en | input | 32 | Machine counter-enable word |
| s_ctr_en | input | 32 | Supervisor counter-enable word |
| bank_rdata | input | XLEN | Old value from the register bank |
| bank_raddr | output | 12 | Bank read address |
| bank_we | output | 1 | Bank write strobe |
| bank_waddr | output | 12 | Bank write address |
| bank_wdata | output | XLEN | Merged write value |
| rdata | output | XLEN | Old value returned to the destination |
| illegal | output | 1 | Access refused |

## Verification
Every result of this block is due in the same cycle as its request, with no register anywhere on the path. The bench therefore sets the address, privilege, operands and bank read value together. It lets one time step settle and samples `illegal`, `bank_we`, `bank_wdata` and `rdata` before touching any input again. No clock edge is needed between stimulus and check, so the clock only paces the scenarios and the watchdog.

// File: rtl/csr_access_gate.sv
module csr_access_gate #(
  parameter int XLEN      = 32,
  parameter int NUM_CTR   = 32,
  parameter bit HAS_SMODE = 1'b1,
  parameter bit HAS_FP    = 1'b1
) (
  input  logic            req_valid,
  input  logic [11:0]     csr_addr,
  input  logic [1:0]      priv,
  input  logic [1:0]      op,
  input  logic [XLEN-1:0] new_val,
  input  logic [XLEN-1:0] wr_mask,
  input  logic [31:0]     m_ctr_en,
  input  logic [31:0]     s_ctr_en,
  input  logic [XLEN-1:0] bank_rdata,
  output logic [11:0]     bank_raddr,
  output logic            bank_we,
  output logic [11:0]     bank_waddr,
  output logic [XLEN-1:0] bank_wdata,
  output logic [XLEN-1:0] rdata,
  output logic            illegal
);
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_M = 2'd3;
  localparam bit         HI_CTR = (XLEN == 32);

  localparam logic [1:0] OP_RAW = 2'd0;
  localparam logic [1:0] OP_SWP = 2'd1;
  localparam logic [1:0] OP_SET = 2'd2;

  function automatic logic in_rng(input logic [11:0] a, input int base, input int cnt);
    return (int'(a) >= base) && (int'(a) < base + cnt);
  endfunction

  logic [XLEN-1:0] eff_new, eff_mask;
  always_comb begin
    case (op)
      OP_RAW:  begin eff_new = new_val;  eff_mask = wr_mask; end
      OP_SWP:  begin eff_new = new_val;  eff_mask = '1;      end
      OP_SET:  begin eff_new = '1;       eff_mask = new_val; end
      default: begin eff_new = '0;       eff_mask = new_val; end
    endcase
  end

  logic [4:0] ctr_idx;
  logic       ctr_idx_ok, uctr_hit, mctr_hit;
  assign ctr_idx    = csr_addr[4:0];
  assign ctr_idx_ok = int'(ctr_idx) < NUM_CTR;
  assign uctr_hit   = (csr_addr[11:5] == 7'h60) || (HI_CTR && csr_addr[11:5] == 7'h64);
  assign mctr_hit   = (csr_addr[11:5] == 7'h58) || (HI_CTR && csr_addr[11:5] == 7'h5C);

  logic fp_hit, s_hit, m_hit, info_hit, impl;
  assign fp_hit   = HAS_FP && in_rng(csr_addr, 'h001, 3);
  assign s_hit    = HAS_SMODE && (in_rng(csr_addr, 'h100, 7) ||
                                  in_rng(csr_addr, 'h140, 5) ||
                                  csr_addr == 12'h180);
  assign m_hit    = in_rng(csr_addr, 'h300, 7) || in_rng(csr_addr, 'h323, 29) ||
                    in_rng(csr_addr, 'h340, 5);
  assign info_hit = in_rng(csr_addr, 'hF11, 4);
  assign impl     = fp_hit | s_hit | m_hit | info_hit | ((uctr_hit | mctr_hit) & ctr_idx_ok);

  logic [31:0] ctr_gate;
  always_comb begin
    ctr_gate = '1;
    if (priv != PRIV_M) ctr_gate = ctr_gate & m_ctr_en;
    if (priv == PRIV_U) ctr_gate = ctr_gate & s_ctr_en;
  end

  logic wr_any, priv_low, ro_viol, ctr_viol, bad, ok;
  assign wr_any   = |eff_mask;
  assign priv_low = priv < csr_addr[9:8];
  assign ro_viol  = (csr_addr[11:10] == 2'b11) & wr_any;
  assign ctr_viol = uctr_hit & ~ctr_gate[ctr_idx];
  assign bad      = ~impl | priv_low | ro_viol | ctr_viol;
  assign ok       = req_valid & ~bad;

  assign illegal    = req_valid & bad;
  assign bank_raddr = csr_addr;
  assign bank_waddr = csr_addr;
  assign bank_we    = ok & wr_any;
  assign bank_wdata = (bank_rdata & ~eff_mask) | (eff_new & eff_mask);
  assign rdata      = ok ? bank_rdata : '0;
endmodule

// File: rtl/csr_access_gate_chk.sv
module csr_access_gate_chk #(
  parameter int XLEN = 32
) (
  input logic            req_valid,
  input logic [11:0]     csr_addr,
  input logic [1:0]      priv,
  input logic [1:0]      op,
  input logic [XLEN-1:0] new_val,
  input logic [XLEN-1:0] wr_mask,
  input logic [31:0]     s_ctr_en,
  input logic [XLEN-1:0] bank_rdata,
  input logic [11:0]     bank_raddr,
  input logic            bank_we,
  input logic [XLEN-1:0] bank_wdata,
  input logic [XLEN-1:0] rdata,
  input logic            illegal
);
  always_comb begin
    if (!$isunknown({req_valid, csr_addr, priv, op, new_val, wr_mask, s_ctr_en,
                     bank_rdata, bank_raddr, bank_we, bank_wdata, rdata, illegal})) begin
      if (req_valid && priv < csr_addr[9:8])
        assert_priv_gate_R1: assert (illegal);
      if (req_valid && csr_addr[11:10] == 2'b11 && op == 2'd1)
        assert_ro_refuse_R2: assert (illegal && !bank_we);
      if (bank_we && op == 2'd0)
        assert_merge_R3: assert (bank_wdata == ((bank_rdata & ~wr_mask) | (new_val & wr_mask)));
      if (op == 2'd0 && wr_mask == '0)
        assert_no_strobe_R4: assert (!bank_we);
      if (bank_we && op == 2'd1)
        assert_swap_R5: assert (bank_wdata == new_val);
      if (illegal || !req_valid)
        assert_quiet_R6: assert (!bank_we && rdata == '0);
      if (req_valid && csr_addr[11:5] == 7'h60 && priv == 2'd0 && !s_ctr_en[csr_addr[4:0]])
        assert_ctr_gate_R7: assert (illegal);
      assert_raddr_R10: assert (bank_raddr == csr_addr);
    end
  end
endmodule

bind csr_access_gate csr_access_gate_chk #(.XLEN(XLEN)) u_chk (
  .req_valid(req_valid), .csr_addr(csr_addr), .priv(priv), .op(op),
  .new_val(new_val), .wr_mask(wr_mask), .s_ctr_en(s_ctr_en),
  .bank_rdata(bank_rdata), .bank_raddr(bank_raddr), .bank_we(bank_we),
  .bank_wdata(bank_wdata), .rdata(rdata), .illegal(illegal)
);

// File: tb/sim_csr_access_gate.sv
module sim_csr_access_gate;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] OLD = 32'hA5A5_0F0F;

  logic        clk = 1'b0;
  logic        req_valid;
  logic [11:0] csr_addr;
  logic [1:0]  priv, op;
  logic [31:0] new_val, wr_mask, m_ctr_en, s_ctr_en, bank_rdata;
  logic [11:0] bank_raddr, bank_waddr, n_raddr, n_waddr;
  logic        bank_we, illegal, n_we, n_illegal;
  logic [31:0] bank_wdata, rdata, n_wdata, n_rdata;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_access_gate u0 (
    .req_valid(req_valid), .csr_addr(csr_addr), .priv(priv), .op(op),
    .new_val(new_val), .wr_mask(wr_mask), .m_ctr_en(m_ctr_en), .s_ctr_en(s_ctr_en),
    .bank_rdata(bank_rdata), .bank_raddr(bank_raddr), .bank_we(bank_we),
    .bank_waddr(bank_waddr), .bank_wdata(bank_wdata), .rdata(rdata), .illegal(illegal)
  );

  csr_access_gate #(.HAS_SMODE(1'b0)) u_nos (
    .req_valid(req_valid), .csr_addr(csr_addr), .priv(priv), .op(op),
    .new_val(new_val), .wr_mask(wr_mask), .m_ctr_en(m_ctr_en), .s_ctr_en(s_ctr_en),
    .bank_rdata(bank_rdata), .bank_raddr(n_raddr), .bank_we(n_we),
    .bank_waddr(n_waddr), .bank_wdata(n_wdata), .rdata(n_rdata), .illegal(n_illegal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [11:0] a, input logic [1:0] p, input logic [1:0] o,
                       input logic [31:0] nv, input logic [31:0] m);
    @(negedge clk);
    req_valid = 1'b1; csr_addr = a; priv = p; op = o; new_val = nv; wr_mask = m;
    bank_rdata = OLD;
    #1;
  endtask

  task automatic t_idle;
    @(negedge clk);
    req_valid = 1'b0; csr_addr = 12'h340; priv = 2'd3; op = 2'd1;
    new_val = 32'h1; wr_mask = '1; m_ctr_en = '1; s_ctr_en = '1; bank_rdata = OLD;
    #1;
    chk("R6 idle illegal", {31'd0, illegal}, 32'd0);
    chk("R4 idle we", {31'd0, bank_we}, 32'd0);
    chk("R6 idle rdata", rdata, 32'd0);
  endtask

  task automatic t_priv;
    drive(12'h340, 2'd0, 2'd0, 0, 0); chk("R1 user->mach", {31'd0, illegal}, 1);
    drive(12'h340, 2'd1, 2'd0, 0, 0); chk("R1 sup->mach", {31'd0, illegal}, 1);
    drive(12'h340, 2'd3, 2'd0, 0, 0); chk("R1 mach->mach", {31'd0, illegal}, 0);
    chk("R6 legal rdata", rdata, OLD);
    drive(12'h140, 2'd1, 2'd0, 0, 0); chk("R1 sup->sup", {31'd0, illegal}, 0);
    drive(12'h140, 2'd0, 2'd0, 0, 0); chk("R1 user->sup", {31'd0, illegal}, 1);
    chk("R6 illegal rdata", rdata, 32'd0);
  endtask

  task automatic t_readonly;
    drive(12'hF11, 2'd3, 2'd0, 32'h5, 32'h0); chk("R2 ro read", {31'd0, illegal}, 0);
    chk("R2 ro read data", rdata, OLD);
    drive(12'hF11, 2'd3, 2'd0, 32'h5, 32'h1); chk("R2 ro write", {31'd0, illegal}, 1);
    chk("R2 ro no strobe", {31'd0, bank_we}, 0);
    drive(12'hF12, 2'd3, 2'd2, 32'h0, 32'hFFFF); chk("R2 ro set zero", {31'd0, illegal}, 0);
    chk("R4 ro set zero we", {31'd0, bank_we}, 0);
  endtask

  task automatic t_merge;
    drive(12'h340, 2'd3, 2'd0, 32'h1234_5678, 32'h0000_FFFF);
    chk("R3 merge data", bank_wdata, 32'hA5A5_5678);
    chk("R3 waddr", {20'd0, bank_waddr}, 32'h340);
    chk("R4 merge we", {31'd0, bank_we}, 1);
    chk("R6 old returned", rdata, OLD);
    drive(12'h340, 2'd3, 2'd0, 32'hFFFF_FFFF, 32'h0);
    chk("R4 zero mask we", {31'd0, bank_we}, 0);
    chk("R4 zero mask rdata", rdata, OLD);
  endtask

  task automatic t_ops;
    drive(12'h341, 2'd3, 2'd1, 32'hDEAD_BEEF, 32'h0);
    chk("R5 swap data", bank_wdata, 32'hDEAD_BEEF); chk("R5 swap we", {31'd0, bank_we}, 1);
    drive(12'h341, 2'd3, 2'd2, 32'h0000_00F0, 32'h0);
    chk("R5 set data", bank_wdata, 32'hA5A5_0FFF);
    drive(12'h341, 2'd3, 2'd3, 32'h0F0F_0000, 32'hFFFF_FFFF);
    chk("R5 clear data", bank_wdata, 32'hA0A0_0F0F);
    drive(12'h341, 2'd3, 2'd3, 32'h0, 32'hFFFF_FFFF);
    chk("R5 clear zero we", {31'd0, bank_we}, 0);
  endtask

  task automatic t_counters;
    m_ctr_en = '0; s_ctr_en = '0;
    drive(12'hC02, 2'd3, 2'd0, 0, 0); chk("R7 mach ungated", {31'd0, illegal}, 0);
    drive(12'hC02, 2'd1, 2'd0, 0, 0); chk("R7 sup m off", {31'd0, illegal}, 1);
    m_ctr_en = 32'h0000_0004;
    drive(12'hC02, 2'd1, 2'd0, 0, 0); chk("R7 sup m on", {31'd0, illegal}, 0);
    drive(12'hC02, 2'd0, 2'd0, 0, 0); chk("R7 user s off", {31'd0, illegal}, 1);
    s_ctr_en = 32'h0000_0004;
    drive(12'hC02, 2'd0, 2'd0, 0, 0); chk("R7 user both on", {31'd0, illegal}, 0);
    drive(12'hC03, 2'd0, 2'd0, 0, 0); chk("R7 user other idx", {31'd0, illegal}, 1);
    s_ctr_en = '0;
    drive(12'hC82, 2'd0, 2'd0, 0, 0); chk("R7 user hi half", {31'd0, illegal}, 1);
    drive(12'hB02, 2'd3, 2'd1, 32'h7, 0); chk("R7 mcounter free", {31'd0, illegal}, 0);
    m_ctr_en = '1; s_ctr_en = '1;
  endtask

  task automatic t_map;
    drive(12'h7C0, 2'd3, 2'd0, 0, 0); chk("R8 7C0", {31'd0, illegal}, 1);
    drive(12'h3A0, 2'd3, 2'd0, 0, 0); chk("R8 3A0", {31'd0, illegal}, 1);
    drive(12'h305, 2'd3, 2'd0, 0, 0); chk("R8 305", {31'd0, illegal}, 0);
    drive(12'h307, 2'd3, 2'd0, 0, 0); chk("R8 307", {31'd0, illegal}, 1);
    drive(12'h33F, 2'd3, 2'd0, 0, 0); chk("R8 33F", {31'd0, illegal}, 0);
    drive(12'hF15, 2'd3, 2'd0, 0, 0); chk("R8 F15", {31'd0, illegal}, 1);
    drive(12'h002, 2'd0, 2'd1, 32'h3, 0); chk("R8 user fp", {31'd0, illegal}, 0);
    chk("R10 raddr", {20'd0, bank_raddr}, 32'h002);
    drive(12'h180, 2'd3, 2'd0, 0, 0); chk("R8 180", {31'd0, illegal}, 0);
  endtask

  task automatic t_nosmode;
    drive(12'h180, 2'd3, 2'd0, 0, 0); chk("R9 no-S 180", {31'd0, n_illegal}, 1);
    drive(12'h105, 2'd3, 2'd1, 32'h1, 0); chk("R9 no-S 105", {31'd0, n_illegal}, 1);
    chk("R9 no-S we", {31'd0, n_we}, 0);
    drive(12'h300, 2'd3, 2'd0, 0, 0); chk("R9 no-S mach ok", {31'd0, n_illegal}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_idle;
    t_priv;
    t_readonly;
    t_merge;
    t_ops;
    t_counters;
    t_map;
    t_nosmode;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule